// File: doc/BRIEF.md
# Scan Source Selector for a Multiplexed Fluorescent Display Driver

This block decides which of three stored 32-bit segment words reaches the segment drivers on each clock, and whether any segment is allowed to light at that moment. One strap input sets its role. As the leader, it follows the chip's own scan timing. That timing supplies a grid code, a brightness pulse and the grid strobes, and all three are passed on to the cascade outputs.

As a follower, it ignores its own scan timing. A 2-bit grid code and a brightness pulse arrive from a leader chip and pass through a two-flop synchronizer. The code picks the stored word and the pulse gates it. In this role the grid strobes are parked high and the cascade outputs are parked low. Chaining a leader and a follower this way extends the segment count of one display tube.

All outputs are registered. A leader-mode change appears one clock after the input. A follower-mode change appears three clocks after the input: two synchronizer stages and then the output register.

Top module: `scan_src_select`

## Requirements
- R1: With `lead_mode`=1, one clock after the inputs, `seg_on` equals the stored word picked by `tgen_code` (1 picks `seg_words[31:0]`, 2 picks `[63:32]`, 3 picks `[95:64]`). It is all zero when `tgen_code`=0 or `tgen_dim`=0.
- R2: With `lead_mode`=1, the values on `peer_sync` and `peer_dim` have no effect on any output.
- R3: With `lead_mode`=1, one clock after the inputs, `grid_drv` equals `tgen_grid`, `dim_cascade` equals `tgen_dim` and `sync_cascade` equals `tgen_code`.
- R4: With `lead_mode`=0 and `peer_dim`=1, `seg_on` follows the word picked by `peer_sync`. The code is {line2, line1} = {`peer_sync[1]`, `peer_sync[0]`], so 1 picks word 1, 2 picks word 2 and 3 picks word 3.
- R5: With `lead_mode`=0 and `peer_sync`=0, `seg_on` is all zero.
- R6: With `lead_mode`=0 and `peer_dim`=0, `seg_on` is all zero.
- R7: With `lead_mode`=0, `grid_drv` is 3'b111, `dim_cascade` is 0 and `sync_cascade` is 2'b00.
- R8: `seg_on[n]` is bit n of the picked word, with no reordering.
- R9: While `rst` is high, every output reads 0 after the first clock edge.
- R10: In follower mode, a change on `peer_dim` or `peer_sync` reaches `seg_on` on the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_mode | input | 1 | 1 selects leader, 0 selects follower |
| seg_words | input | 96 | Three stored segment words, word 1 in the low bits |
| tgen_code | input | 2 | Grid code from the internal scan timer |
| tgen_dim | input | 1 | Brightness pulse from the internal scan timer |
| tgen_grid | input | 3 | Grid strobes from the internal scan timer |
| peer_sync | input | 2 | Grid code from a leader chip (asynchronous) |
| peer_dim | input | 1 | Brightness pulse from a leader chip (asynchronous) |
| seg_on | output | 32 | Segment enables, 1 = lit |
| grid_drv | output | 3 | Grid strobes |
| dim_cascade | output | 1 | Brightness pulse toward a follower |
| sync_cascade | output | 2 | Grid code toward a follower |

## Verification
Gating and word selection fall in the same cycle. A nonzero grid code can arrive together with a low brightness pulse, and the gate must win over the picked word. The bench sweeps every code and pulse pair in both roles. In leader mode it drives the peer inputs to the inverse values, so any leakage from the wrong source shows up as a wrong word. A timed edge on the follower pulse also checks that the word appears on the third rising edge and not one edge earlier.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;
  localparam int DEF_SEG_W  = 32;
  localparam int DEF_GRIDS  = 3;
  localparam int DEF_STAGES = 2;

  function automatic int code_width(input int grids);
    return $clog2(grids + 1);
  endfunction

  typedef enum logic [1:0] {
    ROLE_FOLLOW = 2'b00,
    ROLE_LEAD   = 2'b01
  } role_e;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scan_code_dec.sv
module scan_code_dec #(
  parameter int GRIDS  = 3,
  parameter int CODE_W = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [GRIDS-1:0]  sel
);
  for (genvar g = 0; g < GRIDS; g++) begin : g_dec
    assign sel[g] = (code == CODE_W'(g + 1));
  end
endmodule

// File: rtl/scan_word_mux.sv
module scan_word_mux #(
  parameter int SEG_W = 32,
  parameter int GRIDS = 3
) (
  input  logic [GRIDS*SEG_W-1:0] words,
  input  logic [GRIDS-1:0]       sel,
  input  logic                   gate,
  output logic [SEG_W-1:0]       seg
);
  logic [SEG_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int g = 0; g < GRIDS; g++)
      acc = acc | (words[g*SEG_W +: SEG_W] & {SEG_W{sel[g]}});
    seg = gate ? acc : '0;
  end
endmodule

// File: rtl/scan_src_select.sv
module scan_src_select
  import scan_sel_pkg::*;
#(
  parameter int SEG_W  = DEF_SEG_W,
  parameter int GRIDS  = DEF_GRIDS,
  parameter int STAGES = DEF_STAGES,
  localparam int CODE_W = code_width(GRIDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lead_mode,
  input  logic [GRIDS*SEG_W-1:0] seg_words,
  input  logic [CODE_W-1:0]      tgen_code,
  input  logic                   tgen_dim,
  input  logic [GRIDS-1:0]       tgen_grid,
  input  logic [CODE_W-1:0]      peer_sync,
  input  logic                   peer_dim,
  output logic [SEG_W-1:0]       seg_on,
  output logic [GRIDS-1:0]       grid_drv,
  output logic                   dim_cascade,
  output logic [CODE_W-1:0]      sync_cascade
);
  localparam int SYNC_W = CODE_W + 1;

  role_e              role;
  logic [SYNC_W-1:0]  peer_s;
  logic [CODE_W-1:0]  peer_code_s;
  logic               peer_dim_s;
  logic [CODE_W-1:0]  act_code;
  logic               act_gate;
  logic [GRIDS-1:0]   act_sel;
  logic [SEG_W-1:0]   seg_c;

  assign role = lead_mode ? ROLE_LEAD : ROLE_FOLLOW;

  scan_sync #(.W(SYNC_W), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({peer_dim, peer_sync}),
    .q   (peer_s)
  );
  assign peer_code_s = peer_s[CODE_W-1:0];
  assign peer_dim_s  = peer_s[CODE_W];

  always_comb begin
    if (role == ROLE_LEAD) begin
      act_code = tgen_code;
      act_gate = tgen_dim;
    end else begin
      act_code = peer_code_s;
      act_gate = peer_dim_s;
    end
  end

  scan_code_dec #(.GRIDS(GRIDS), .CODE_W(CODE_W)) u_dec (
    .code (act_code),
    .sel  (act_sel)
  );

  scan_word_mux #(.SEG_W(SEG_W), .GRIDS(GRIDS)) u_mux (
    .words (seg_words),
    .sel   (act_sel),
    .gate  (act_gate),
    .seg   (seg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_on       <= '0;
      grid_drv     <= '0;
      dim_cascade  <= 1'b0;
      sync_cascade <= '0;
    end else begin
      seg_on <= seg_c;
      if (role == ROLE_LEAD) begin
        grid_drv     <= tgen_grid;
        dim_cascade  <= tgen_dim;
        sync_cascade <= tgen_code;
      end else begin
        grid_drv     <= '1;
        dim_cascade  <= 1'b0;
        sync_cascade <= '0;
      end
    end
  end

  // R1
  lead_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (lead_mode && (!tgen_dim || tgen_code == '0)) |=> (seg_on == '0));

  // R3
  lead_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lead_mode |=> (grid_drv == $past(tgen_grid) && dim_cascade == $past(tgen_dim)
                   && sync_cascade == $past(tgen_code)));

  // R4
  follow_word1_chk: assert property (@(posedge clk) disable iff (rst)
    (!lead_mode && peer_dim_s && peer_code_s == CODE_W'(1))
      |=> (seg_on == $past(seg_words[SEG_W-1:0])));

  // R5 R6
  follow_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!lead_mode && (!peer_dim_s || peer_code_s == '0)) |=> (seg_on == '0));

  // R7
  follow_park_chk: assert property (@(posedge clk) disable iff (rst)
    !lead_mode |=> (grid_drv == '1 && !dim_cascade && sync_cascade == '0));
endmodule

// File: tb/scan_src_select_tb.sv
module scan_src_select_tb;
  localparam int SW = 32;
  localparam int NG = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          lead_mode;
  logic [NG*SW-1:0] seg_words;
  logic [1:0]    tgen_code;
  logic          tgen_dim;
  logic [NG-1:0] tgen_grid;
  logic [1:0]    peer_sync;
  logic          peer_dim;
  logic [SW-1:0] seg_on;
  logic [NG-1:0] grid_drv;
  logic          dim_cascade;
  logic [1:0]    sync_cascade;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  scan_src_select u_dut (
    .clk(clk), .rst(rst), .lead_mode(lead_mode), .seg_words(seg_words),
    .tgen_code(tgen_code), .tgen_dim(tgen_dim), .tgen_grid(tgen_grid),
    .peer_sync(peer_sync), .peer_dim(peer_dim), .seg_on(seg_on),
    .grid_drv(grid_drv), .dim_cascade(dim_cascade), .sync_cascade(sync_cascade)
  );

  function automatic logic [SW-1:0] pick(input logic [NG*SW-1:0] w,
                                         input int code, input bit dim);
    if (code == 0 || !dim) return '0;
    return w[(code-1)*SW +: SW];
  endfunction

  function automatic logic [SW-1:0] pat(input int p, input int g);
    logic [SW-1:0] v;
    v = 32'h9E37_79B9 * (p * 3 + g + 1);
    return v ^ (v >> 13) ^ SW'(g * 32'h0101_0101);
  endfunction

  task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lead_mode = 1'b1; seg_words = '1;
    tgen_code = 2'd3; tgen_dim = 1'b1; tgen_grid = 3'b101;
    peer_sync = 2'd3; peer_dim = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 seg", seg_on, '0);
    chk("R9 grid", SW'(grid_drv), '0);
    chk("R9 casc", SW'({dim_cascade, sync_cascade}), '0);
    rst = 1'b0;

    // Sweep: role x code x pulse x word pattern
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 4; p++) begin
            lead_mode = m[0];
            seg_words = {pat(p, 2), pat(p, 1), pat(p, 0)};
            tgen_grid = 3'((c + d * 4 + p) % 8);
            if (m == 1) begin
              tgen_code = 2'(c); tgen_dim = d[0];
              peer_sync = ~2'(c); peer_dim = ~d[0];
            end else begin
              peer_sync = 2'(c); peer_dim = d[0];
              tgen_code = ~2'(c); tgen_dim = ~d[0];
            end
            settle(4);
            if (m == 1) begin
              // R1 R2: word from the timer, peer inputs inverted
              chk("R1/R2 lead seg", seg_on, pick(seg_words, c, d[0]));
              // R3 pass-through
              chk("R3 lead grid", SW'(grid_drv), SW'(tgen_grid));
              chk("R3 lead casc", SW'({dim_cascade, sync_cascade}),
                  SW'({d[0], 2'(c)}));
            end else begin
              // R4 R5 R6
              if (c == 0)      chk("R5 follow no code", seg_on, '0);
              else if (d == 0) chk("R6 follow dim low", seg_on, '0);
              else             chk("R4 follow word", seg_on, pick(seg_words, c, 1'b1));
              // R7 parked outputs
              chk("R7 follow park", SW'({grid_drv, dim_cascade, sync_cascade}),
                  SW'({3'b111, 1'b0, 2'b00}));
            end
          end

    // R8 walking bit: bit n of the picked word lands on seg_on[n]
    lead_mode = 1'b1; tgen_dim = 1'b1;
    for (int n = 0; n < SW; n++)
      for (int c = 1; c < 4; c++) begin
        seg_words = '0;
        seg_words[(c-1)*SW + n] = 1'b1;
        tgen_code = 2'(c);
        settle(1);
        chk("R8 bit order", seg_on, SW'(1) << n);
      end

    // R1 leader latency is one edge
    seg_words = {pat(7, 2), pat(7, 1), pat(7, 0)};
    tgen_code = 2'd2; tgen_dim = 1'b0;
    settle(2);
    tgen_dim = 1'b1;
    settle(1);
    chk("R1 lead one edge", seg_on, pat(7, 1));

    // R10 follower latency: unchanged after two edges, updated on the third
    lead_mode = 1'b0; peer_sync = 2'd1; peer_dim = 1'b0;
    settle(4);
    peer_dim = 1'b1;
    settle(2);
    chk("R10 follow edge2", seg_on, '0);
    settle(1);
    chk("R10 follow edge3", seg_on, pat(7, 0));
    peer_sync = 2'd3;
    settle(2);
    chk("R10 code edge2", seg_on, pat(7, 0));
    settle(1);
    chk("R10 code edge3", seg_on, pat(7, 2));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule